// File: doc/BRIEF.md
# Two-Input Up/Down Counter Stage

This block is a four-bit counter that moves up on one count input and down on a second, separate count input. There is no shared clock plus a direction pin. A count input takes effect on its rising edge, and only while the other count input is held high. A falling edge does nothing.

Three controls sit above counting, in this order of priority:
- A high clear forces the count to zero and beats everything else.
- An active-low load copies a four-bit data word into the count.
- Edges arriving during a short recovery window after either control is released are thrown away.

Two active-low terminal outputs allow stages to be chained. The carry output goes low while the up input is low and the count sits at its top value. The borrow output goes low while the down input is low and the count is zero. Wiring them to the next stage's up and down inputs builds a longer counter.

A parameter chooses between two sequences:
- decimal, 0 to 9;
- binary, 0 to 15.

The stage runs entirely on one system clock. Both count inputs are brought in through two-flop synchronisers, and an edge is a 0-to-1 change of the synchronised level. A rising count edge changes the count on the third system-clock edge after the input changes. Clear and load are sampled on the system clock and act on the following edge.

Top module: `updn_stage`

## Requirements
- R1: After system reset, and on the clock edge after `clr` is sampled high, the count is 0. Clear overrides load and both count inputs.
- R2: With `clr` low and `load_n` low, the count takes the value on `din` on the next clock edge, whatever the count inputs are doing.
- R3: A synchronised rising edge on `up_in` while `dn_in` is high increments the count. A falling edge on `up_in` leaves the count unchanged.
- R4: A synchronised rising edge on `dn_in` while `up_in` is high decrements the count.
- R5: A rising edge on one count input while the other count input is low does not change the count.
- R6: With `DECADE`=1, counting up from 9 (or from any loaded value above 9) gives 0, and counting down from 0 gives 9.
- R7: With `DECADE`=0, counting up from 15 gives 0, and counting down from 0 gives 15.
- R8: `carry_n` is low exactly when the synchronised `up_in` is low and the count is at or above the top value (9 decimal, 15 binary). `borrow_n` is low exactly when the synchronised `dn_in` is low and the count is 0.
- R9: If both count inputs show a synchronised rising edge in the same system-clock cycle, the count is held.
- R10: A count edge detected within `HOLDOFF` clock cycles after `clr` and `load_n` return inactive is discarded. The default `HOLDOFF` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr | input | 1 | Synchronous clear to zero, active high, highest priority |
| load_n | input | 1 | Parallel load, active low |
| up_in | input | 1 | Up-count input, asynchronous, counts on its rising edge |
| dn_in | input | 1 | Down-count input, asynchronous, counts on its rising edge |
| din | input | 4 | Parallel load data |
| q | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal-up output for chaining |
| borrow_n | output | 1 | Active-low terminal-down output for chaining |

## Verification
The bound checker watches, on every cycle, the effects of clear and load. It also checks single steps up and down, the wrap at both ends of the sequence, the hold when both inputs rise together, and the freeze during the recovery window.

Other behaviour can only be shown by the bench's scenarios, which drive the asynchronous pins directly:
- the three-edge latency from a pin change to the count;
- that a falling edge or an unqualified edge leaves the count alone;
- the timing of `carry_n` and `borrow_n` against the pin levels;
- the binary and decimal variants running side by side.

// File: rtl/updn_pkg.sv
package updn_pkg;
    localparam int CNT_W = 4;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_DEC,
        OP_LOAD,
        OP_CLR
    } op_e;
endpackage

// File: rtl/updn_sync.sv
module updn_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = async_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    // Idle level of a count input is high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;
    assign rise  = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/updn_ctrl.sv
module updn_ctrl
    import updn_pkg::*;
#(
    parameter int HOLDOFF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load_n,
    input  logic up_lvl,
    input  logic dn_lvl,
    input  logic up_rise,
    input  logic dn_rise,
    output op_e  op,
    output logic busy
);
    localparam int HW = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);
    localparam logic [HW-1:0] HOLD_INIT = HW'(HOLDOFF);

    typedef struct packed {
        logic [HW-1:0] hold;
    } ctrl_t;

    ctrl_t st_d, st_q;
    op_e   op_d;

    always_comb begin
        st_d = st_q;
        op_d = OP_HOLD;
        if (clr || !load_n) begin
            st_d.hold = HOLD_INIT;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - HW'(1);
        end

        if (clr) begin
            op_d = OP_CLR;
        end else if (!load_n) begin
            op_d = OP_LOAD;
        end else if (st_q.hold != '0) begin
            op_d = OP_HOLD;
        end else if (up_rise && dn_rise) begin
            op_d = OP_HOLD;
        end else if (up_rise && dn_lvl) begin
            op_d = OP_INC;
        end else if (dn_rise && up_lvl) begin
            op_d = OP_DEC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op   = op_d;
    assign busy = (st_q.hold != '0);
endmodule

// File: rtl/updn_count.sv
module updn_count
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  cnt_t din,
    output cnt_t q,
    output logic at_top,
    output logic at_zero
);
    localparam cnt_t TOP = DECADE ? cnt_t'(9) : cnt_t'(15);

    typedef struct packed {
        cnt_t cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLR:  st_d.cnt = '0;
            OP_LOAD: st_d.cnt = din;
            OP_INC:  st_d.cnt = (st_q.cnt >= TOP) ? '0 : st_q.cnt + cnt_t'(1);
            OP_DEC:  st_d.cnt = (st_q.cnt == '0) ? TOP : st_q.cnt - cnt_t'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q       = st_q.cnt;
    assign at_top  = (st_q.cnt >= TOP);
    assign at_zero = (st_q.cnt == '0);
endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter bit DECADE  = 1'b1,
    parameter int HOLDOFF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic             up_in,
    input  logic             dn_in,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] q,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam int NCH = 2;   // channel 0: up, channel 1: down

    logic [NCH-1:0] raw;
    logic [NCH-1:0] lvl;
    logic [NCH-1:0] rise;
    op_e            op;
    logic           holding;
    logic           at_top;
    logic           at_zero;
    cnt_t           cnt;

    assign raw = {dn_in, up_in};

    for (genvar g = 0; g < NCH; g++) begin : g_sync
        updn_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw[g]),
            .level    (lvl[g]),
            .rise     (rise[g])
        );
    end

    updn_ctrl #(.HOLDOFF(HOLDOFF)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .load_n  (load_n),
        .up_lvl  (lvl[0]),
        .dn_lvl  (lvl[1]),
        .up_rise (rise[0]),
        .dn_rise (rise[1]),
        .op      (op),
        .busy    (holding)
    );

    updn_count #(.DECADE(DECADE)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .din     (din),
        .q       (cnt),
        .at_top  (at_top),
        .at_zero (at_zero)
    );

    assign q        = cnt;
    assign carry_n  = ~(~lvl[0] & at_top);
    assign borrow_n = ~(~lvl[1] & at_zero);
endmodule

// File: rtl/updn_stage_chk.sv
module updn_stage_chk
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       load_n,
    input logic [3:0] din,
    input logic [3:0] q,
    input logic [1:0] lvl,
    input logic [1:0] rise,
    input logic       holding
);
    localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

    logic free;
    assign free = !clr && load_n && !holding;

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == 4'd0)); // R1

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (q == $past(din))); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (free && rise[0] && !rise[1] && lvl[1] && q < TOP) |=> (q == $past(q) + 4'd1)); // R3

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (free && rise[1] && !rise[0] && lvl[0] && q != 4'd0) |=> (q == $past(q) - 4'd1)); // R4

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (free && rise[0] && !rise[1] && lvl[1] && q >= TOP) |=> (q == 4'd0)); // R6 R7

    AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (free && rise[1] && !rise[0] && lvl[0] && q == 4'd0) |=> (q == TOP)); // R6 R7

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && rise[0] && rise[1]) |=> $stable(q)); // R9

    AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && holding) |=> $stable(q)); // R10
endmodule

bind updn_stage updn_stage_chk #(.DECADE(DECADE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load_n  (load_n),
    .din     (din),
    .q       (q),
    .lvl     (lvl),
    .rise    (rise),
    .holding (holding)
);

// File: tb/updn_stage_tb.sv
module updn_stage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int RECOVER    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic       up_in = 1'b1;
    logic       dn_in = 1'b1;
    logic [3:0] din = 4'd0;
    logic [3:0] q_d, q_b;
    logic       carry_d, carry_b, borrow_d, borrow_b;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_d   = 0;
    int exp_b   = 0;
    bit done    = 1'b0;

    typedef struct {
        int    ed;
        int    eb;
        string tag;
    } item_t;

    item_t sb[$];
    event  chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_stage #(.DECADE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n),
        .up_in(up_in), .dn_in(dn_in), .din(din),
        .q(q_d), .carry_n(carry_d), .borrow_n(borrow_d)
    );

    updn_stage #(.DECADE(1'b0)) u_bin (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n),
        .up_in(up_in), .dn_in(dn_in), .din(din),
        .q(q_b), .carry_n(carry_b), .borrow_n(borrow_b)
    );

    // Monitor: pops expected counts and compares them with both stages.
    initial begin
        forever begin
            item_t it;
            @(chk_ev);
            while (sb.size() > 0) begin
                it = sb.pop_front();
                n_tests++;
                if (int'(q_d) != it.ed || int'(q_b) != it.eb) begin
                    n_fail++;
                    $display("FAIL %s: decimal q=%0d exp=%0d, binary q=%0d exp=%0d",
                             it.tag, q_d, it.ed, q_b, it.eb);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input string tag);
        item_t it;
        it.ed = exp_d;
        it.eb = exp_b;
        it.tag = tag;
        sb.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b exp %b", tag, act, exp);
        end
    endtask

    function automatic int inc_d(input int v);
        return (v >= 9) ? 0 : v + 1;
    endfunction

    function automatic int dec_d(input int v);
        return (v == 0) ? 9 : v - 1;
    endfunction

    task automatic do_load(input int v, input string tag);
        din = v[3:0];
        load_n = 1'b0;
        wait_clk(2);
        load_n = 1'b1;
        wait_clk(RECOVER);
        exp_d = v;
        exp_b = v;
        push_exp(tag);
    endtask

    task automatic pulse_up(input string tag);
        up_in = 1'b0;
        wait_clk(SETTLE);
        push_exp({tag, " falling edge holds (R3)"});
        up_in = 1'b1;
        wait_clk(SETTLE);
        exp_d = inc_d(exp_d);
        exp_b = (exp_b + 1) % 16;
        push_exp(tag);
    endtask

    task automatic pulse_dn(input string tag);
        dn_in = 1'b0;
        wait_clk(SETTLE);
        dn_in = 1'b1;
        wait_clk(SETTLE);
        exp_d = dec_d(exp_d);
        exp_b = (exp_b + 15) % 16;
        push_exp(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        push_exp("R1 reset state");
        check_bit("R8 carry idle", carry_d, 1'b1);
        check_bit("R8 borrow idle", borrow_d, 1'b1);

        do_load(7, "R2 load 7");
        pulse_up("R3 up 7->8");
        pulse_up("R3 up 8->9");

        // Carry: up low while decimal count is 9; binary count 9 is below its top.
        up_in = 1'b0;
        wait_clk(SETTLE);
        check_bit("R8 carry low at 9 decimal", carry_d, 1'b0);
        check_bit("R8 carry high at 9 binary", carry_b, 1'b1);
        up_in = 1'b1;
        wait_clk(SETTLE);
        exp_d = inc_d(exp_d);
        exp_b = (exp_b + 1) % 16;
        push_exp("R6 decimal 9->0, binary 9->10");
        check_bit("R8 carry released", carry_d, 1'b1);

        // Borrow: down low while decimal count is 0.
        dn_in = 1'b0;
        wait_clk(SETTLE);
        check_bit("R8 borrow low at 0", borrow_d, 1'b0);
        check_bit("R8 borrow high at 10 binary", borrow_b, 1'b1);
        dn_in = 1'b1;
        wait_clk(SETTLE);
        exp_d = dec_d(exp_d);
        exp_b = (exp_b + 15) % 16;
        push_exp("R4 R6 decimal 0->9, binary 10->9");

        // Qualification: up edge while down is low has no effect.
        dn_in = 1'b0;
        wait_clk(SETTLE);
        up_in = 1'b0;
        wait_clk(SETTLE);
        up_in = 1'b1;
        wait_clk(SETTLE);
        push_exp("R5 up edge with down low ignored");
        dn_in = 1'b1;
        wait_clk(SETTLE);
        exp_d = dec_d(exp_d);
        exp_b = (exp_b + 15) % 16;
        push_exp("R4 down edge with up high 9->8");

        // Both inputs rise in the same cycle.
        up_in = 1'b0;
        dn_in = 1'b0;
        wait_clk(SETTLE);
        up_in = 1'b1;
        dn_in = 1'b1;
        wait_clk(SETTLE);
        push_exp("R9 simultaneous edges hold");

        // Clear beats load and counting.
        din = 4'd5;
        load_n = 1'b0;
        clr = 1'b1;
        up_in = 1'b0;
        wait_clk(2);
        up_in = 1'b1;
        wait_clk(2);
        exp_d = 0;
        exp_b = 0;
        push_exp("R1 clear overrides load");
        clr = 1'b0;
        load_n = 1'b1;
        wait_clk(RECOVER);
        push_exp("R1 still zero after release");

        // Binary wrap.
        do_load(15, "R2 load 15");
        pulse_up("R7 R6 up from 15");
        pulse_dn("R7 R6 down from 0");

        // Recovery window after load.
        up_in = 1'b0;
        wait_clk(SETTLE);
        din = 4'd3;
        load_n = 1'b0;
        wait_clk(2);
        load_n = 1'b1;
        up_in = 1'b1;
        wait_clk(RECOVER);
        exp_d = 3;
        exp_b = 3;
        push_exp("R10 edge inside recovery discarded");
        pulse_up("R10 R3 edge after recovery counts");
        pulse_dn("R4 down 4->3");

        wait_clk(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule